// File: doc/BRIEF.md
# Hypervisor Interrupt-Pending View Unit

This block keeps one physical interrupt-pending register and presents it to software as several control-register views: the machine view, the supervisor view, the hypervisor view, the hypervisor injection view and the guest (virtual supervisor) view. It also holds the two delegation masks that shape those views, and the guest external interrupt path: a latched vector of guest interrupt lines, an enable vector, and a guest index field that picks which guest line drives the guest external pending bit.

A control-register port selects one view with `csr_sel`. Reads return data in the same cycle. Writes land on the next rising clock edge. `pend_o` carries the combined pending vector to the interrupt arbiter that sits downstream. The number of guest external lines is the parameter `GEI_N`, and it may be zero.

Top module: `hip_alias`

## Requirements
- R1: Reading view code 0 (machine) returns exactly `pend_o`. Every other pending view is derived from this same vector.
- R2: The hypervisor delegation mask (view 5) stores only bits 2, 6 and 10. All its other bits read zero, including the supervisor-level bits 1, 5, 9 and 12.
- R3: The machine delegation mask (view 6) reads one at bits 2, 6, 10 and 12 whatever is written. Bits 1, 5 and 9 are writable. All other bits read zero. The supervisor view (view 1) returns the pending vector ANDed with this mask.
- R4: A write to the injection view (view 3) stores only bits 2 (VS software), 6 (VS timer) and 10 (VS external). Reading view 3 returns only those stored bits.
- R5: A bit stored through view 3 shows at the same position of `pend_o`, of the machine view and of the hypervisor view (view 2, which is the pending vector masked to bits 2, 6, 10 and 12) from the next cycle on.
- R6: The guest view (view 4) places pending bit n at bit n-1 for n in {2, 6, 10}, and only where the hypervisor delegation mask has bit n set. All its other bits read zero.
- R7: When `GEI_N` > 0, pending bit 10 is also set in the cycle where the latched guest line selected by the guest index (view 9, 6 bits) and its enable bit are both one. Guest line k is latched one cycle after input into bit k+1 of view 7. The enable vector (view 8) stores only bits 1..`GEI_N`.
- R8: A guest index of 0, or one greater than `GEI_N`, selects no guest line.
- R9: Pending bit 12 equals the OR over all bits of (view 7 AND view 8).
- R10: With `GEI_N` = 0, views 7 and 8 and pending bit 12 read zero at all times.
- R11: Pending bits other than 2, 6, 10 and 12 follow `irq_lines` one cycle later. Raw lines at 2, 6, 10 and 12 are ignored. Writes to views 0, 1, 2, 4 and 7, and to codes 10 to 15, change no state. Codes 10 to 15 read zero.
- R12: After synchronous reset the pending vector, both writable delegation bits, the injection bits, the guest enables and the guest index are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 16 | Raw interrupt request lines |
| gei_lines | input | max(GEI_N,1) | Guest external interrupt lines |
| csr_sel | input | 4 | View code selected for read and write |
| csr_we | input | 1 | Write strobe for the selected view |
| csr_wdata | input | 16 | Write data |
| csr_rdata | output | 16 | Read data of the selected view |
| pend_o | output | 16 | Combined pending vector |

## Verification
Every view is combinational from the single pending register. A corrupted stored bit therefore shows up in the next cycle both on `pend_o` and on whichever view the bench happens to select. A fault that only moves an alias, such as a wrong shift in the guest view or a wrong fixed delegation bit, shows only while that view is selected. For this reason the bench sweeps the view code every cycle and compares against a behavioural model. Guest-selection faults need matching line, enable and index values to become visible, so directed steps set those values explicitly before the random sweep starts.

// File: rtl/hip_alias_pkg.sv
package hip_alias_pkg;

    localparam int IRQ_W   = 16;
    localparam int VGEIN_W = 6;

    localparam int VSSIP_B = 2;
    localparam int VSTIP_B = 6;
    localparam int VSEIP_B = 10;
    localparam int SGEIP_B = 12;

    localparam logic [IRQ_W-1:0] VS_MASK    = (IRQ_W'(1) << VSSIP_B) | (IRQ_W'(1) << VSTIP_B)
                                            | (IRQ_W'(1) << VSEIP_B);
    localparam logic [IRQ_W-1:0] HV_MASK    = VS_MASK | (IRQ_W'(1) << SGEIP_B);
    localparam logic [IRQ_W-1:0] MDELEG_WR  = VS_MASK >> 1;
    localparam logic [IRQ_W-1:0] MDELEG_ONE = HV_MASK;
    localparam logic [IRQ_W-1:0] RAW_MASK   = ~HV_MASK;

    typedef enum logic [3:0] {
        V_MIP     = 4'd0,
        V_SIP     = 4'd1,
        V_HIP     = 4'd2,
        V_HVIP    = 4'd3,
        V_VSIP    = 4'd4,
        V_HIDELEG = 4'd5,
        V_MIDELEG = 4'd6,
        V_HGEIP   = 4'd7,
        V_HGEIE   = 4'd8,
        V_VGEIN   = 4'd9
    } csr_view_e;

    function automatic logic [IRQ_W-1:0] guest_view(input logic [IRQ_W-1:0] pend,
                                                    input logic [IRQ_W-1:0] hdeleg);
        return (pend & hdeleg & VS_MASK) >> 1;
    endfunction

endpackage

// File: rtl/hip_deleg_regs.sv
module hip_deleg_regs
    import hip_alias_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we_hdeleg,
    input  logic             we_mdeleg,
    input  logic [IRQ_W-1:0] wdata,
    output logic [IRQ_W-1:0] hdeleg,
    output logic [IRQ_W-1:0] mdeleg
);
    logic [IRQ_W-1:0] hdeleg_q;
    logic [IRQ_W-1:0] mdeleg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hdeleg_q <= '0;
            mdeleg_q <= '0;
        end else begin
            if (we_hdeleg) hdeleg_q <= wdata & VS_MASK;
            if (we_mdeleg) mdeleg_q <= wdata & MDELEG_WR;
        end
    end

    assign hdeleg = hdeleg_q;
    assign mdeleg = mdeleg_q | MDELEG_ONE;
endmodule

// File: rtl/hip_gei.sv
module hip_gei
    import hip_alias_pkg::*;
#(
    parameter int GEI_N = 4,
    localparam int GEI_W = (GEI_N > 0) ? GEI_N : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [GEI_W-1:0]   gei_lines,
    input  logic               we_enable,
    input  logic               we_index,
    input  logic [IRQ_W-1:0]   wdata,
    input  logic [VGEIN_W-1:0] idx_wdata,
    output logic [IRQ_W-1:0]   gpend,
    output logic [IRQ_W-1:0]   genab,
    output logic [VGEIN_W-1:0] gindex,
    output logic               gsel_hit,
    output logic               gany
);
    logic [VGEIN_W-1:0] gindex_q;

    always_ff @(posedge clk) begin
        if (rst)           gindex_q <= '0;
        else if (we_index) gindex_q <= idx_wdata;
    end
    assign gindex = gindex_q;

    generate
        if (GEI_N > 0) begin : g_lines
            localparam logic [IRQ_W-1:0] GMASK = ((IRQ_W'(1) << GEI_N) - IRQ_W'(1)) << 1;
            logic [IRQ_W-1:0] gpend_q;
            logic [IRQ_W-1:0] genab_q;
            logic [IRQ_W-1:0] active;

            always_ff @(posedge clk) begin
                if (rst) begin
                    gpend_q <= '0;
                    genab_q <= '0;
                end else begin
                    gpend_q <= (IRQ_W'(gei_lines) << 1) & GMASK;
                    if (we_enable) genab_q <= wdata & GMASK;
                end
            end

            assign active   = gpend_q & genab_q;
            assign gpend    = gpend_q;
            assign genab    = genab_q;
            assign gany     = |active;
            assign gsel_hit = (gindex_q != '0) && (int'(gindex_q) <= GEI_N)
                              && active[gindex_q[3:0]];
        end else begin : g_none
            logic unused_gei;
            assign unused_gei = ^{gei_lines, we_enable, wdata};
            assign gpend      = '0;
            assign genab      = '0;
            assign gany       = 1'b0;
            assign gsel_hit   = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/hip_pend_core.sv
module hip_pend_core
    import hip_alias_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IRQ_W-1:0] irq_lines,
    input  logic             we_inject,
    input  logic [IRQ_W-1:0] wdata,
    input  logic             gsel_hit,
    input  logic             gany,
    output logic [IRQ_W-1:0] pend,
    output logic [IRQ_W-1:0] inject
);
    logic [IRQ_W-1:0] pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            pend_q[IRQ_W-1:0] <= (irq_lines & RAW_MASK)
                               | (we_inject ? (wdata & VS_MASK) : (pend_q & VS_MASK));
        end
    end

    assign inject = pend_q & VS_MASK;

    always_comb begin
        pend          = pend_q;
        pend[VSEIP_B] = pend_q[VSEIP_B] | gsel_hit;
        pend[SGEIP_B] = gany;
    end
endmodule

// File: rtl/hip_alias.sv
module hip_alias
    import hip_alias_pkg::*;
#(
    parameter int GEI_N = 4,
    localparam int GEI_W = (GEI_N > 0) ? GEI_N : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [IRQ_W-1:0]   irq_lines,
    input  logic [GEI_W-1:0]   gei_lines,
    input  logic [3:0]         csr_sel,
    input  logic               csr_we,
    input  logic [IRQ_W-1:0]   csr_wdata,
    output logic [IRQ_W-1:0]   csr_rdata,
    output logic [IRQ_W-1:0]   pend_o
);
    csr_view_e          view;
    logic [IRQ_W-1:0]   hdeleg, mdeleg, gpend, genab, inject, pend;
    logic [VGEIN_W-1:0] gindex;
    logic               gsel_hit, gany;

    assign view = csr_view_e'(csr_sel);

    hip_deleg_regs u_deleg (
        .clk       (clk),
        .rst       (rst),
        .we_hdeleg (csr_we && view == V_HIDELEG),
        .we_mdeleg (csr_we && view == V_MIDELEG),
        .wdata     (csr_wdata),
        .hdeleg    (hdeleg),
        .mdeleg    (mdeleg)
    );

    hip_gei #(.GEI_N(GEI_N)) u_gei (
        .clk       (clk),
        .rst       (rst),
        .gei_lines (gei_lines),
        .we_enable (csr_we && view == V_HGEIE),
        .we_index  (csr_we && view == V_VGEIN),
        .wdata     (csr_wdata),
        .idx_wdata (csr_wdata[VGEIN_W-1:0]),
        .gpend     (gpend),
        .genab     (genab),
        .gindex    (gindex),
        .gsel_hit  (gsel_hit),
        .gany      (gany)
    );

    hip_pend_core u_core (
        .clk       (clk),
        .rst       (rst),
        .irq_lines (irq_lines),
        .we_inject (csr_we && view == V_HVIP),
        .wdata     (csr_wdata),
        .gsel_hit  (gsel_hit),
        .gany      (gany),
        .pend      (pend),
        .inject    (inject)
    );

    assign pend_o = pend;

    always_comb begin
        unique case (view)
            V_MIP:     csr_rdata = pend;
            V_SIP:     csr_rdata = pend & mdeleg;
            V_HIP:     csr_rdata = pend & HV_MASK;
            V_HVIP:    csr_rdata = inject;
            V_VSIP:    csr_rdata = guest_view(pend, hdeleg);
            V_HIDELEG: csr_rdata = hdeleg;
            V_MIDELEG: csr_rdata = mdeleg;
            V_HGEIP:   csr_rdata = gpend;
            V_HGEIE:   csr_rdata = genab;
            V_VGEIN:   csr_rdata = IRQ_W'(gindex);
            default:   csr_rdata = '0;
        endcase
    end
endmodule

// File: rtl/hip_alias_chk.sv
module hip_alias_chk
    import hip_alias_pkg::*;
#(
    parameter int GEI_N = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [IRQ_W-1:0] irq_lines,
    input logic [3:0]       csr_sel,
    input logic             csr_we,
    input logic [IRQ_W-1:0] csr_wdata,
    input logic [IRQ_W-1:0] csr_rdata,
    input logic [IRQ_W-1:0] pend_o
);
    // R1
    mip_view_chk: assert property (@(posedge clk) disable iff (rst)
        csr_sel == 4'd0 |-> csr_rdata == pend_o);

    // R2
    hideleg_ro_chk: assert property (@(posedge clk) disable iff (rst)
        csr_sel == 4'd5 |-> (csr_rdata & ~VS_MASK) == '0);

    // R3
    mideleg_hw_chk: assert property (@(posedge clk) disable iff (rst)
        csr_sel == 4'd6 |-> (csr_rdata & MDELEG_ONE) == MDELEG_ONE);

    // R4
    hvip_scope_chk: assert property (@(posedge clk) disable iff (rst)
        csr_sel == 4'd3 |-> (csr_rdata & ~VS_MASK) == '0);

    // R5
    vseip_inject_chk: assert property (@(posedge clk) disable iff (rst)
        (csr_we && csr_sel == 4'd3 && csr_wdata[VSEIP_B]) |=> pend_o[VSEIP_B]);

    // R11
    raw_rise_chk: assert property (@(posedge clk) disable iff (rst)
        irq_lines[7] |=> pend_o[7]);

    // R11
    raw_fall_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_lines[7] |=> !pend_o[7]);

    // R10
    no_guest_chk: assert property (@(posedge clk) disable iff (rst)
        (GEI_N == 0 && (csr_sel == 4'd7 || csr_sel == 4'd8)) |-> csr_rdata == '0);
endmodule

bind hip_alias hip_alias_chk #(.GEI_N(GEI_N)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq_lines (irq_lines),
    .csr_sel   (csr_sel),
    .csr_we    (csr_we),
    .csr_wdata (csr_wdata),
    .csr_rdata (csr_rdata),
    .pend_o    (pend_o)
);

// File: tb/hip_alias_tb.sv
module hip_alias_tb;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] irq = '0;
    logic [3:0]  gei = '0;
    logic [3:0]  sel = '0;
    logic        we  = 1'b0;
    logic [15:0] wd  = '0;
    logic [15:0] rd, pend, rd_z, pend_z;

    int tests = 0;
    int fails = 0;

    // bench model state
    logic [15:0] m_raw, m_vs, m_hdel, m_mdw, m_hgp, m_hge;
    int          m_idx;

    always #5 clk = ~clk;

    hip_alias #(.GEI_N(N)) u_dut (
        .clk(clk), .rst(rst), .irq_lines(irq), .gei_lines(gei), .csr_sel(sel),
        .csr_we(we), .csr_wdata(wd), .csr_rdata(rd), .pend_o(pend));

    hip_alias #(.GEI_N(0)) u_dut_z (
        .clk(clk), .rst(rst), .irq_lines(irq), .gei_lines(gei[0]), .csr_sel(sel),
        .csr_we(we), .csr_wdata(wd), .csr_rdata(rd_z), .pend_o(pend_z));

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_pend(input logic [15:0] hgp, input logic [15:0] hge,
                                              input int n);
        logic [15:0] p = m_raw | m_vs;
        logic [15:0] act = hgp & hge;
        if (m_idx >= 1 && m_idx <= n && act[m_idx]) p[10] = 1'b1;
        if (act != 0) p[12] = 1'b1;
        return p;
    endfunction

    function automatic logic [15:0] exp_read(input int s, input logic [15:0] p,
                                             input logic [15:0] hgp, input logic [15:0] hge);
        logic [15:0] r = '0;
        case (s)
            0: r = p;
            1: r = p & (m_mdw | 16'h1444);
            2: r = p & 16'h1444;
            3: r = m_vs;
            4: foreach (r[b]) if ((b == 2 || b == 6 || b == 10) && m_hdel[b]) r[b-1] = p[b];
            5: r = m_hdel;
            6: r = m_mdw | 16'h1444;
            7: r = hgp;
            8: r = hge;
            9: r = 16'(m_idx);
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic string tag_of(input int s);
        case (s)
            0: return "R1 machine view";
            1: return "R3 supervisor view";
            2: return "R5 hypervisor view";
            3: return "R4 injection view";
            4: return "R6 guest view";
            5: return "R2 hyp delegation";
            6: return "R3 machine delegation";
            7: return "R9 guest pending";
            8: return "R9 guest enable";
            9: return "R8 guest index";
            default: return "R11 unused code";
        endcase
    endfunction

    task automatic model_update();
        if (rst) begin
            m_raw = '0; m_vs = '0; m_hdel = '0; m_mdw = '0; m_hgp = '0; m_hge = '0; m_idx = 0;
        end else begin
            m_raw = irq & 16'hEBBB;
            m_hgp = ({12'b0, gei} << 1) & 16'h001E;
            if (we) begin
                case (sel)
                    3: m_vs   = wd & 16'h0444;
                    5: m_hdel = wd & 16'h0444;
                    6: m_mdw  = wd & 16'h0222;
                    8: m_hge  = wd & 16'h001E;
                    9: m_idx  = int'(wd[5:0]);
                    default: ;
                endcase
            end
        end
    endtask

    task automatic compare_all();
        logic [15:0] p  = exp_pend(m_hgp, m_hge, N);
        logic [15:0] pz = exp_pend(16'h0, 16'h0, 0);
        check(pend, p, "R1/R7 pending vector");
        check(rd, exp_read(int'(sel), p, m_hgp, m_hge), tag_of(int'(sel)));
        check(pend_z, pz, "R10 zero-guest pending");
        check(rd_z, exp_read(int'(sel), pz, 16'h0, 16'h0), "R10 zero-guest read");
    endtask

    task automatic step(input logic [15:0] i, input logic [3:0] g, input logic [3:0] s,
                        input logic w, input logic [15:0] d);
        @(negedge clk);
        irq = i; gei = g; sel = s; we = w; wd = d;
        #2 compare_all();
        @(posedge clk);
        model_update();
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        m_raw = '0; m_vs = '0; m_hdel = '0; m_mdw = '0; m_hgp = '0; m_hge = '0; m_idx = 0;
        irq = 16'hFFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0; irq = '0; sel = 4'd6;
        #2;
        // R12 reset state
        check(pend, 16'h1000 & 16'h0, "R12 reset pending");
        check(rd, 16'h1444, "R12 reset machine delegation");
        sel = 4'd0;
        #1 check(rd, 16'h0000, "R12 reset machine view");
        @(posedge clk); model_update();

        // R2, R3 delegation masks
        step(16'h0, 4'h0, 4'd5, 1'b1, 16'hFFFF);
        step(16'h0, 4'h0, 4'd5, 1'b0, 16'h0);
        step(16'h0, 4'h0, 4'd6, 1'b1, 16'hFFFF);
        step(16'h0, 4'h0, 4'd6, 1'b0, 16'h0);
        // R4, R5, R6 injection and aliases
        step(16'h0, 4'h0, 4'd3, 1'b1, 16'hFFFF);
        for (int s = 0; s < 5; s++) step(16'h0, 4'h0, 4'(s), 1'b0, 16'h0);
        step(16'h0, 4'h0, 4'd3, 1'b1, 16'h0);
        // R11 writes to read-only views change nothing, raw lines follow
        for (int s = 0; s < 16; s++)
            if (s == 0 || s == 1 || s == 2 || s == 4 || s == 7 || s >= 10)
                step(16'hFFFF, 4'h0, 4'(s), 1'b1, 16'hFFFF);
        step(16'h0, 4'h0, 4'd0, 1'b0, 16'h0);
        // R7, R8, R9 guest selection
        step(16'h0, 4'h0, 4'd8, 1'b1, 16'h001E);
        step(16'h0, 4'h4, 4'd9, 1'b1, 16'd3);
        step(16'h0, 4'h4, 4'd4, 1'b0, 16'h0);
        step(16'h0, 4'h4, 4'd2, 1'b0, 16'h0);
        step(16'h0, 4'h4, 4'd9, 1'b1, 16'd0);
        step(16'h0, 4'h4, 4'd0, 1'b0, 16'h0);
        step(16'h0, 4'hF, 4'd9, 1'b1, 16'd5);
        step(16'h0, 4'hF, 4'd0, 1'b0, 16'h0);
        step(16'h0, 4'hF, 4'd9, 1'b1, 16'd4);
        step(16'h0, 4'h8, 4'd7, 1'b0, 16'h0);
        step(16'h0, 4'h0, 4'd0, 1'b0, 16'h0);

        // random sweep over all views
        for (int k = 0; k < 800; k++) begin
            logic [3:0]  s = 4'($urandom % 12);
            logic [15:0] d = 16'($urandom);
            if (s == 4'd9) d = 16'($urandom % 8);
            step(16'($urandom), 4'($urandom), s, 1'($urandom), d);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule